// File: doc/BRIEF.md
# Streaming Image Resizer

This block scales a raster of single-channel pixels on each axis by its own factor. Pixels enter on a valid/ready stream. A start-of-frame flag marks the first pixel of a frame and an end-of-line flag marks the last pixel of each row. Each axis has a step register N, and the scale factor on that axis is 256/N, so N = 64 gives 4x enlargement and N = 1024 gives 1/4x reduction.

A phase accumulator with 8 fractional bits sets the position of each output sample. Each output is a rounded linear blend of the two neighbouring source samples. Rows are first resampled horizontally into one of two line banks. When a row is complete, the vertical stage blends the two most recent stored rows and emits as many output rows as the vertical phase allows. That can be zero rows, one row or several rows.

A source row therefore yields the outputs whose position lies at or past its left neighbour and before it. Output position k sits at k·N/256 on the source grid. A sample is produced only when both neighbours exist, so a row of W pixels gives the outputs with ⌊k·N/256⌋ < W−1. A frame of H rows gives the rows with ⌊r·Nv/256⌋ < H−1.

Top module: `img_resizer`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: A step value below 64 is used as 64, and a value above 1024 is used as 1024. Steps from 64 to 1024 are used unchanged.
- R3: Both step inputs are sampled only when a pixel with `in_sof` high is accepted. Changes to them during a frame have no effect on that frame.
- R4: Horizontal output k of a row is (a·(256−f) + b·f + 128) >> 8, where p = k·Nh, a is source pixel p>>8, b is the pixel after it, and f = p & 255. The row holds every k with (p>>8) < W−1.
- R5: Output row r blends horizontally scaled source rows i = (r·Nv)>>8 and i+1 with weight f = (r·Nv) & 255, using the same rounding as R4. The frame holds every r with i < H−1.
- R6: `out_sof` is high only on the first pixel of the first output row of a frame. `out_eol` is high only on the last pixel of each output row.
- R7: `in_ready` is low while one source pixel still has more outputs to produce, and while the vertical stage emits rows. No pixel is lost or duplicated.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sof` and `out_eol` hold their values.
- R9: Both phase accumulators restart at zero at every row start and every frame start. Each row and each frame is resampled the same way regardless of earlier data.
- R10: A frame with one row, or rows of one pixel, produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_hstep | input | 11 | Horizontal step N (scale 256/N) |
| cfg_vstep | input | 11 | Vertical step N (scale 256/N) |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_data | input | PIX_W | Input pixel |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a row |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output pixel |
| out_data | output | PIX_W | Output pixel |
| out_sof | output | 1 | First output pixel of a frame |
| out_eol | output | 1 | Last output pixel of a row |

## Verification
The assertions assume that every row of a frame has the same width, and that a row has at most IN_MAX pixels and yields at most LINE_MAX outputs. They assume a frame has at most MAX_ROWS rows, and that `in_sof` arrives only on the first pixel of a row. The directed frames are built to meet all of these limits, with every frame starting on `in_sof` and every row ending on `in_eol`. Stimulus inputs change only after a clock edge, and handshakes are observed half a cycle before the edge that completes them.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
  localparam int FRAC_W = 8;
  localparam int STEP_W = 11;
  localparam logic [STEP_W-1:0] STEP_MIN = 11'd64;
  localparam logic [STEP_W-1:0] STEP_MAX = 11'd1024;
  localparam logic [STEP_W-1:0] STEP_UNITY = 11'd256;

  typedef enum logic {V_IDLE, V_EMIT} vstate_t;

  function automatic logic [STEP_W-1:0] clamp_step(input logic [STEP_W-1:0] s);
    if (s < STEP_MIN) return STEP_MIN;
    if (s > STEP_MAX) return STEP_MAX;
    return s;
  endfunction
endpackage

// File: rtl/rsz_lerp.sv
module rsz_lerp #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0]          a,
  input  logic [PIX_W-1:0]          b,
  input  logic [rsz_pkg::FRAC_W-1:0] frac,
  output logic [PIX_W-1:0]          y
);
  import rsz_pkg::*;
  localparam int ACC_W = PIX_W + FRAC_W + 1;

  logic [ACC_W-1:0] wa, wb, acc;

  always_comb begin
    wb  = ACC_W'(frac);
    wa  = ACC_W'(1 << FRAC_W) - wb;
    acc = ACC_W'(a) * wa + ACC_W'(b) * wb + ACC_W'(1 << (FRAC_W - 1));
    y   = acc[FRAC_W +: PIX_W];
  end
endmodule

// File: rtl/rsz_hscale.sv
module rsz_hscale #(
  parameter int PIX_W    = 8,
  parameter int IN_MAX   = 512,
  parameter int LINE_MAX = 128,
  localparam int AW = $clog2(LINE_MAX),
  localparam int LW = $clog2(LINE_MAX + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [PIX_W-1:0]           in_data,
  input  logic                       in_sof,
  input  logic                       in_eol,
  input  logic                       hold,
  input  logic [rsz_pkg::STEP_W-1:0] step,
  output logic                       frame_start,
  output logic                       wr_en,
  output logic [AW-1:0]              wr_addr,
  output logic [PIX_W-1:0]           wr_data,
  output logic                       line_done,
  output logic [LW-1:0]              line_len
);
  import rsz_pkg::*;
  localparam int CW   = $clog2(IN_MAX + 1);
  localparam int HA_W = CW + FRAC_W;

  logic [CW-1:0]    cnt, hint, cnt_m2;
  logic [HA_W-1:0]  hacc;
  logic [PIX_W-1:0] s_prev, s_cur;
  logic [LW-1:0]    ocnt;
  logic             eol_pend, emit, accept, room;

  assign hint   = hacc[HA_W-1:FRAC_W];
  assign cnt_m2 = cnt - CW'(2);
  assign emit   = (cnt >= CW'(2)) && (hint == cnt_m2);
  assign room   = ocnt < LW'(LINE_MAX);

  assign in_ready    = !emit && !eol_pend && !hold;
  assign accept      = in_valid && in_ready;
  assign frame_start = accept && in_sof;
  assign line_done   = eol_pend && !emit;
  assign line_len    = ocnt;
  assign wr_en       = emit && room;
  assign wr_addr     = AW'(ocnt);

  rsz_lerp #(.PIX_W(PIX_W)) u_lerp (
    .a(s_prev), .b(s_cur), .frac(hacc[FRAC_W-1:0]), .y(wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      hacc     <= '0;
      ocnt     <= '0;
      s_prev   <= '0;
      s_cur    <= '0;
      eol_pend <= 1'b0;
    end else begin
      if (accept) begin
        s_prev   <= s_cur;
        s_cur    <= in_data;
        eol_pend <= in_eol;
        if (in_sof) begin
          cnt  <= CW'(1);
          hacc <= '0;
          ocnt <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
      if (emit) begin
        hacc <= hacc + HA_W'(step);
        if (room) ocnt <= ocnt + LW'(1);
      end
      if (line_done) begin
        cnt      <= '0;
        hacc     <= '0;
        ocnt     <= '0;
        eol_pend <= 1'b0;
      end
    end
  end

  // R4
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= CW'(2)) |-> (hint >= cnt_m2));

  // R9
  line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> (hacc == '0 && cnt == '0 && !emit));
endmodule

// File: rtl/rsz_linebuf.sv
module rsz_linebuf #(
  parameter int PIX_W    = 8,
  parameter int LINE_MAX = 128,
  localparam int AW = $clog2(LINE_MAX)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             wr_bank,
  input  logic [AW-1:0]    wr_addr,
  input  logic [PIX_W-1:0] wr_data,
  input  logic             cur_bank,
  input  logic [AW-1:0]    rd_addr,
  output logic [PIX_W-1:0] rd_new,
  output logic [PIX_W-1:0] rd_old
);
  logic [PIX_W-1:0] rd_bank [2];

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [PIX_W-1:0] mem [LINE_MAX];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(g))) mem[wr_addr] <= wr_data;
    end
    assign rd_bank[g] = mem[rd_addr];
  end

  assign rd_new = rd_bank[cur_bank];
  assign rd_old = rd_bank[~cur_bank];
endmodule

// File: rtl/rsz_vscale.sv
module rsz_vscale #(
  parameter int PIX_W    = 8,
  parameter int LINE_MAX = 128,
  parameter int MAX_ROWS = 512,
  localparam int AW = $clog2(LINE_MAX),
  localparam int LW = $clog2(LINE_MAX + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_start,
  input  logic                       line_done,
  input  logic [LW-1:0]              line_len,
  input  logic [rsz_pkg::STEP_W-1:0] step,
  output logic                       bank,
  output logic [AW-1:0]              rd_addr,
  input  logic [PIX_W-1:0]           rd_new,
  input  logic [PIX_W-1:0]           rd_old,
  output logic                       busy,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [PIX_W-1:0]           out_data,
  output logic                       out_sof,
  output logic                       out_eol
);
  import rsz_pkg::*;
  localparam int RW   = $clog2(MAX_ROWS + 1);
  localparam int VA_W = RW + FRAC_W;

  vstate_t         state;
  logic [RW-1:0]   lines, lines_m2, new_lines, vint, vint_next;
  logic [VA_W-1:0] vacc, vnext;
  logic [LW-1:0]   x, width;
  logic            sof_pend, take, row_end;

  assign vint      = vacc[VA_W-1:FRAC_W];
  assign vnext     = vacc + VA_W'(step);
  assign vint_next = vnext[VA_W-1:FRAC_W];
  assign lines_m2  = lines - RW'(2);
  assign new_lines = lines + RW'(1);

  assign busy      = (state == V_EMIT);
  assign out_valid = busy;
  assign rd_addr   = AW'(x);
  assign out_eol   = busy && (x == width - LW'(1));
  assign out_sof   = busy && sof_pend && (x == '0);
  assign take      = out_valid && out_ready;
  assign row_end   = take && out_eol;

  rsz_lerp #(.PIX_W(PIX_W)) u_lerp (
    .a(rd_old), .b(rd_new), .frac(vacc[FRAC_W-1:0]), .y(out_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= V_IDLE;
      lines    <= '0;
      vacc     <= '0;
      x        <= '0;
      width    <= '0;
      bank     <= 1'b0;
      sof_pend <= 1'b0;
    end else begin
      if (frame_start) begin
        lines    <= '0;
        vacc     <= '0;
        sof_pend <= 1'b1;
      end
      if (state == V_IDLE && line_done) begin
        lines <= new_lines;
        width <= line_len;
        x     <= '0;
        if (new_lines >= RW'(2) && line_len != '0 && vint == new_lines - RW'(2))
          state <= V_EMIT;
        else
          bank <= ~bank;
      end
      if (take) begin
        sof_pend <= 1'b0;
        if (row_end) begin
          x    <= '0;
          vacc <= vnext;
          if (vint_next != lines_m2) begin
            state <= V_IDLE;
            bank  <= ~bank;
          end
        end else begin
          x <= x + LW'(1);
        end
      end
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_eol) && $stable(out_sof)));

  // R5
  vert_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (vint == lines_m2));

  // R6
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_end |=> (x == '0));
endmodule

// File: rtl/img_resizer.sv
module img_resizer #(
  parameter int PIX_W    = 8,
  parameter int IN_MAX   = 512,
  parameter int LINE_MAX = 128,
  parameter int MAX_ROWS = 512
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [rsz_pkg::STEP_W-1:0] cfg_hstep,
  input  logic [rsz_pkg::STEP_W-1:0] cfg_vstep,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [PIX_W-1:0]           in_data,
  input  logic                       in_sof,
  input  logic                       in_eol,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [PIX_W-1:0]           out_data,
  output logic                       out_sof,
  output logic                       out_eol
);
  import rsz_pkg::*;
  localparam int AW = $clog2(LINE_MAX);
  localparam int LW = $clog2(LINE_MAX + 1);

  logic [STEP_W-1:0] nh_q, nv_q;
  logic              frame_start, wr_en, line_done, v_busy, bank;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [PIX_W-1:0]  wr_data, rd_new, rd_old;
  logic [LW-1:0]     line_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nh_q <= STEP_UNITY;
      nv_q <= STEP_UNITY;
    end else if (frame_start) begin
      nh_q <= clamp_step(cfg_hstep);
      nv_q <= clamp_step(cfg_vstep);
    end
  end

  rsz_hscale #(.PIX_W(PIX_W), .IN_MAX(IN_MAX), .LINE_MAX(LINE_MAX)) u_hscale (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_sof, .in_eol,
    .hold(v_busy), .step(nh_q), .frame_start,
    .wr_en, .wr_addr, .wr_data, .line_done, .line_len
  );

  rsz_linebuf #(.PIX_W(PIX_W), .LINE_MAX(LINE_MAX)) u_linebuf (
    .clk, .wr_en, .wr_bank(bank), .wr_addr, .wr_data,
    .cur_bank(bank), .rd_addr, .rd_new, .rd_old
  );

  rsz_vscale #(.PIX_W(PIX_W), .LINE_MAX(LINE_MAX), .MAX_ROWS(MAX_ROWS)) u_vscale (
    .clk, .rst_n, .frame_start, .line_done, .line_len, .step(nv_q),
    .bank, .rd_addr, .rd_new, .rd_old, .busy(v_busy),
    .out_valid, .out_ready, .out_data, .out_sof, .out_eol
  );

  // R2
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nh_q >= STEP_MIN && nh_q <= STEP_MAX && nv_q >= STEP_MIN && nv_q <= STEP_MAX));

  // R3
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(nh_q) && $stable(nv_q)));

  // R7
  no_write_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !v_busy);
endmodule

// File: tb/img_resizer_bench.sv
module img_resizer_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [10:0] cfg_hstep = 11'd256, cfg_vstep = 11'd256;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0, in_ready;
  logic [7:0]  in_data = '0;
  logic        out_valid, out_ready = 1'b1, out_sof, out_eol;
  logic [7:0]  out_data;

  img_resizer u_img_resizer (
    .clk, .rst_n, .cfg_hstep, .cfg_vstep, .in_valid, .in_ready, .in_data,
    .in_sof, .in_eol, .out_valid, .out_ready, .out_data, .out_sof, .out_eol
  );

  int n_chk = 0, n_fail = 0;
  int img [16][32];
  int hrow [16][128];
  int W, H;
  int exp_d [2048]; bit exp_s [2048]; bit exp_e [2048]; int nexp;
  int got_d [2048]; bit got_s [2048]; bit got_e [2048]; int ngot;
  int n_stall, bp_viol, bp_cyc = 0;
  bit bp_mode = 0, pend = 0, ps, pe;
  logic [7:0] pd;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    bp_cyc++;
    out_ready = bp_mode ? ((bp_cyc % 3) != 1) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (pend && !(out_valid && out_data == pd && out_sof == ps && out_eol == pe))
        bp_viol++;
      pend = out_valid && !out_ready;
      pd = out_data; ps = out_sof; pe = out_eol;
      if (in_valid && !in_ready) n_stall++;
      if (out_valid && out_ready && ngot < 2048) begin
        got_d[ngot] = out_data; got_s[ngot] = out_sof; got_e[ngot] = out_eol;
        ngot++;
      end
    end
  end

  function automatic int clampi(input int v);
    return (v < 64) ? 64 : ((v > 1024) ? 1024 : v);
  endfunction

  function automatic int mix(input int a, input int b, input int f);
    return (a * (256 - f) + b * f + 128) >> 8;
  endfunction

  task automatic fill(input int w, input int h, input int seed);
    W = w; H = h;
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++)
        img[y][x] = (y * 37 + x * 53 + seed * 11 + ((x * y) % 7) * 19) & 255;
  endtask

  task automatic build_model(input int nh_raw, input int nv_raw);
    int nh, nv, hw, p, i, f;
    nh = clampi(nh_raw); nv = clampi(nv_raw);
    hw = 0;
    while (((hw * nh) >> 8) < W - 1) hw++;
    for (int y = 0; y < H; y++)
      for (int k = 0; k < hw; k++) begin
        p = k * nh; i = p >> 8; f = p & 255;
        hrow[y][k] = mix(img[y][i], img[y][i + 1], f);
      end
    nexp = 0;
    if (hw > 0)
      for (int r = 0; ((r * nv) >> 8) < H - 1; r++) begin
        p = r * nv; i = p >> 8; f = p & 255;
        for (int k = 0; k < hw; k++) begin
          exp_d[nexp] = mix(hrow[i][k], hrow[i + 1][k], f);
          exp_s[nexp] = (r == 0 && k == 0);
          exp_e[nexp] = (k == hw - 1);
          nexp++;
        end
      end
  endtask

  task automatic send_frame(input int chg_row, input int nh2, input int nv2);
    bit acc;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        if (y == chg_row && x == 0) begin
          cfg_hstep = 11'(nh2); cfg_vstep = 11'(nv2);
        end
        in_valid = 1'b1; in_data = 8'(img[y][x]);
        in_sof = (x == 0 && y == 0); in_eol = (x == W - 1);
        do begin
          @(negedge clk); acc = in_ready;
          @(posedge clk); #1;
        end while (!acc);
      end
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
  endtask

  task automatic run_frame(input int nh, input int nv, input int chg_row,
                           input int nh2, input int nv2);
    int t;
    ngot = 0; n_stall = 0; bp_viol = 0;
    cfg_hstep = 11'(nh); cfg_vstep = 11'(nv);
    send_frame(chg_row, nh2, nv2);
    t = 0;
    while (ngot < nexp && t < 4000) begin @(posedge clk); t++; end
    repeat (40) @(posedge clk);
    #1;
  endtask

  task automatic compare(input string req);
    int bad, bflag;
    bad = -1; bflag = -1;
    check(ngot == nexp, {req, " count"}, ngot, nexp);
    for (int n = 0; n < nexp && n < ngot; n++) begin
      if (bad < 0 && got_d[n] != exp_d[n]) bad = n;
      if (bflag < 0 && (got_s[n] != exp_s[n] || got_e[n] != exp_e[n])) bflag = n;
    end
    if (bad < 0) check(1'b1, {req, " data"}, 0, 0);
    else check(1'b0, {req, " data"}, got_d[bad], exp_d[bad]);
    // R6 flags
    if (bflag < 0) check(1'b1, "R6 flags", 0, 0);
    else check(1'b0, "R6 flags", got_s[bflag] * 2 + got_e[bflag],
               exp_s[bflag] * 2 + exp_e[bflag]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic t_unity();
    fill(6, 4, 1); build_model(256, 256);
    run_frame(256, 256, -1, 0, 0);
    compare("R4 R5 unity");
  endtask

  task automatic t_upscale();
    fill(5, 3, 2); build_model(128, 128);
    run_frame(128, 128, -1, 0, 0);
    compare("R4 R5 upscale");
    check(n_stall > 0, "R7 stall seen", n_stall, 1);
  endtask

  task automatic t_downscale();
    fill(20, 9, 3); build_model(600, 1024);
    run_frame(600, 1024, -1, 0, 0);
    compare("R4 R5 R9 downscale");
    fill(13, 7, 4); build_model(300, 200);
    run_frame(300, 200, -1, 0, 0);
    compare("R9 next frame");
  endtask

  task automatic t_clamp();
    fill(4, 9, 5); build_model(10, 2000);
    run_frame(10, 2000, -1, 0, 0);
    compare("R2 clamp");
    check(nexp == 24, "R2 size", nexp, 24);
  endtask

  task automatic t_midframe();
    fill(6, 4, 6); build_model(256, 256);
    run_frame(256, 256, 2, 100, 100);
    compare("R3 midframe");
    build_model(100, 100);
    run_frame(100, 100, -1, 0, 0);
    compare("R3 next sof");
  endtask

  task automatic t_backpressure();
    bp_mode = 1;
    fill(7, 5, 7); build_model(96, 160);
    run_frame(96, 160, -1, 0, 0);
    compare("R8 R7 backpressure");
    check(bp_viol == 0, "R8 hold", bp_viol, 0);
    bp_mode = 0;
  endtask

  task automatic t_tiny();
    fill(5, 1, 8); build_model(128, 128);
    run_frame(128, 128, -1, 0, 0);
    check(ngot == 0, "R10 one row", ngot, 0);
    fill(1, 4, 9); build_model(128, 128);
    run_frame(128, 128, -1, 0, 0);
    check(ngot == 0, "R10 one column", ngot, 0);
    fill(6, 4, 10); build_model(256, 256);
    run_frame(256, 256, -1, 0, 0);
    compare("R9 after tiny");
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    @(posedge clk); #1;
    t_unity();
    t_upscale();
    t_downscale();
    t_clamp();
    t_midframe();
    t_backpressure();
    t_tiny();
    finish_up();
  end
endmodule